// File: doc/BRIEF.md
# Single-Wire Slave Bit Timing Engine

This block is the bit-level engine of a slave device on a single open-drain wire. It receives an already synchronised sample of the wire and a system clock. From the clock it derives a microsecond tick. It recognises reset lows and answers each one with a presence low. It decodes master write slots into received bits. During read slots it pulls the wire low when the command layer asks it to send a 0.

Two speeds are supported: standard and overdrive. The command layer moves the engine into overdrive with a one-cycle request. A very long reset low returns it to standard speed.

After every rising edge there is a hold-off window. A short low glitch inside that window does not open a slot. At standard speed, a falling edge must also hold for several clocks before a slot is opened.

All time thresholds are fixed microsecond counts, scaled by the parameter `CLKS_PER_US`. The standard-speed limits are: reset 240, sample 30, read drive 30, presence wait 30, presence low 120, hold-off 3. The overdrive limits are: reset 32, sample 4, read drive 3, presence wait 3, presence low 12, hold-off 1. Overdrive is left when a single low reaches 240.

Top module: `sw_slave_phy`

## Requirements
- R1: At standard speed, a low lasting 240 us or more gives exactly one `reset_seen` pulse of one cycle. A low of 80 us gives none.
- R2: When the wire rises after a detected reset, `pull_low` asserts about 30 us later and stays high for exactly 120 us (standard speed).
- R3: A write slot gives exactly one one-cycle `rx_valid` strobe.
  - If the wire is back high before 30 us, `rx_bit` is 1.
  - If the wire is still low at 30 us, `rx_bit` is 0.
- R4: With `tx_en`=1 at the slot start:
  - `tx_bit`=0 makes `pull_low` stay high for exactly 30 us from the slot start.
  - `tx_bit`=1 never asserts `pull_low`.
  - No `rx_valid` strobe is produced in either case.
- R5: A one-cycle `od_enter` sets `overdrive` to 1. In overdrive a 1 us low decodes as 1 and an 8 us low decodes as 0, with a sample point at 4 us.
- R6: In overdrive, a 50 us low gives one `reset_seen` pulse. The presence that follows lasts 12 us, and `overdrive` stays 1.
- R7: In overdrive, a low reaching 240 us clears `overdrive` while the wire is low. The presence that follows uses standard timing (120 us).
- R8: A low that starts inside the hold-off window after a rising edge and ends inside it yields no strobe. A low that is still present when the window ends opens a new slot.
- R9: At standard speed, a low shorter than `FALL_FILT_CLKS` consecutive samples opens no slot.
- R10: While and right after `rst`, `pull_low`, `rx_valid`, `reset_seen` and `overdrive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Synchronised wire level, 1 = released/high |
| od_enter | input | 1 | One-cycle request from the command layer to switch to overdrive |
| tx_en | input | 1 | Next slot is a read slot (slave transmits) |
| tx_bit | input | 1 | Bit to transmit in the next read slot |
| rx_valid | output | 1 | One-cycle strobe: a write-slot bit was decoded |
| rx_bit | output | 1 | Decoded bit value, valid with `rx_valid` |
| reset_seen | output | 1 | One-cycle pulse when a reset low is recognised |
| pull_low | output | 1 | Enable for the open-drain pull-down |
| overdrive | output | 1 | Current speed, 1 = overdrive |

## Verification
A corrupted slot counter or timing selection shows up at the ports within one slot. The presence low, or the read-slot drive length, moves away from its exact microsecond count. A bit decodes to the wrong value at the sample point.

A speed register stuck in either state becomes visible on the next reset. That reset has the wrong presence length, or it keeps overdrive after a long low.

A hold-off or falling-edge filter that is absent turns a short glitch into an extra `rx_valid` strobe. The strobe appears within 30 us of the glitch.

// File: rtl/sw_phy_pkg.sv
package sw_phy_pkg;

    // Microsecond thresholds for each speed
    localparam int STD_RST_US   = 240;
    localparam int STD_SMP_US   = 30;
    localparam int STD_DRV_US   = 30;
    localparam int STD_PWAIT_US = 30;
    localparam int STD_PLOW_US  = 120;
    localparam int STD_HOLD_US  = 3;

    localparam int OD_RST_US    = 32;
    localparam int OD_SMP_US    = 4;
    localparam int OD_DRV_US    = 3;
    localparam int OD_PWAIT_US  = 3;
    localparam int OD_PLOW_US   = 12;
    localparam int OD_HOLD_US   = 1;

    // Single low length that drops overdrive back to standard speed
    localparam int OD_EXIT_US   = 240;

    localparam int CNT_W = $clog2(OD_EXIT_US + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_HOLD,
        ST_PWAIT,
        ST_PDRIVE
    } slot_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] rst_us;
        logic [CNT_W-1:0] smp_us;
        logic [CNT_W-1:0] drv_us;
        logic [CNT_W-1:0] pwait_us;
        logic [CNT_W-1:0] plow_us;
        logic [CNT_W-1:0] hold_us;
    } speed_timing_t;

    function automatic speed_timing_t timing_for(input logic od);
        speed_timing_t t;
        if (od) begin
            t.rst_us   = CNT_W'(OD_RST_US);
            t.smp_us   = CNT_W'(OD_SMP_US);
            t.drv_us   = CNT_W'(OD_DRV_US);
            t.pwait_us = CNT_W'(OD_PWAIT_US);
            t.plow_us  = CNT_W'(OD_PLOW_US);
            t.hold_us  = CNT_W'(OD_HOLD_US);
        end else begin
            t.rst_us   = CNT_W'(STD_RST_US);
            t.smp_us   = CNT_W'(STD_SMP_US);
            t.drv_us   = CNT_W'(STD_DRV_US);
            t.pwait_us = CNT_W'(STD_PWAIT_US);
            t.plow_us  = CNT_W'(STD_PLOW_US);
            t.hold_us  = CNT_W'(STD_HOLD_US);
        end
        return t;
    endfunction

endpackage

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
    parameter int CLKS_PER_US = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

    logic [DIV_W-1:0] div;

    assign tick = (div == DIV_W'(CLKS_PER_US - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div <= '0;
        end else if (tick) begin
            div <= '0;
        end else begin
            div <= div + 1'b1;
        end
    end
endmodule

// File: rtl/sw_fall_filter.sv
module sw_fall_filter #(
    parameter int FALL_FILT_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_in,
    input  logic overdrive,
    output logic low_qual
);
    generate
        if (FALL_FILT_CLKS <= 1) begin : g_nofilt
            assign low_qual = !bus_in;
        end else begin : g_filt
            localparam int RUN_W = $clog2(FALL_FILT_CLKS + 1);
            logic [RUN_W-1:0] run;

            always_ff @(posedge clk) begin
                if (rst || bus_in) begin
                    run <= '0;
                end else if (run != RUN_W'(FALL_FILT_CLKS)) begin
                    run <= run + 1'b1;
                end
            end

            // Overdrive: the first low sample counts.
            // Standard: the low must persist for FALL_FILT_CLKS samples.
            assign low_qual = !bus_in &&
                              (overdrive || (run >= RUN_W'(FALL_FILT_CLKS - 1)));
        end
    endgenerate
endmodule

// File: rtl/sw_slot_ctrl.sv
module sw_slot_ctrl
    import sw_phy_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_in,
    input  logic low_qual,
    input  logic us_tick,
    input  logic tx_en,
    input  logic tx_bit,
    input  logic od_enter,
    output logic tick_clr,
    output logic pull_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic reset_seen,
    output logic overdrive
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] EXIT_CNT = CNT_W'(OD_EXIT_US);

    slot_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_inc, cnt_n;
    logic             rx_pend, drv0, rst_flag, od;
    logic             rx_fire, rx_val_n, rst_fire, od_clr;
    speed_timing_t    tm;

    assign tm      = timing_for(od);
    assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    always_comb begin
        state_n  = state;
        rx_fire  = 1'b0;
        rx_val_n = 1'b0;
        rst_fire = 1'b0;
        od_clr   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (low_qual) state_n = ST_SLOT;
            end
            ST_SLOT: begin
                if (bus_in) begin
                    // Line released before the sample point: a 1
                    if (rx_pend) begin
                        rx_fire  = 1'b1;
                        rx_val_n = 1'b1;
                    end
                    state_n = rst_flag ? ST_PWAIT : ST_HOLD;
                end else if (us_tick) begin
                    if (rx_pend && cnt_inc == tm.smp_us) begin
                        rx_fire  = 1'b1;
                        rx_val_n = 1'b0;
                    end
                    if (!rst_flag && cnt_inc == tm.rst_us) rst_fire = 1'b1;
                    if (od && cnt_inc == EXIT_CNT)         od_clr   = 1'b1;
                end
            end
            ST_PWAIT: begin
                if (low_qual) begin
                    state_n = ST_SLOT;
                end else if (us_tick && cnt_inc == tm.pwait_us) begin
                    state_n = ST_PDRIVE;
                end
            end
            ST_PDRIVE: begin
                if (us_tick && cnt_inc == tm.plow_us) state_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (us_tick && cnt_inc == tm.hold_us) begin
                    state_n = bus_in ? ST_IDLE : ST_SLOT;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        tick_clr = (state_n != state);
        if (state_n != state) begin
            cnt_n = '0;
        end else if (us_tick) begin
            cnt_n = cnt_inc;
        end else begin
            cnt_n = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            rx_pend    <= 1'b0;
            drv0       <= 1'b0;
            rst_flag   <= 1'b0;
            od         <= 1'b0;
            rx_valid   <= 1'b0;
            rx_bit     <= 1'b0;
            reset_seen <= 1'b0;
        end else begin
            state      <= state_n;
            cnt        <= cnt_n;
            rx_valid   <= rx_fire;
            reset_seen <= rst_fire;
            if (rx_fire) rx_bit <= rx_val_n;

            if (state_n == ST_SLOT && state != ST_SLOT) begin
                rx_pend  <= !tx_en;
                drv0     <= tx_en && !tx_bit;
                rst_flag <= 1'b0;
            end else begin
                if (rx_fire) rx_pend <= 1'b0;
                if (rst_fire) begin
                    rst_flag <= 1'b1;
                    rx_pend  <= 1'b0;
                    drv0     <= 1'b0;
                end
            end

            if (od_clr) begin
                od <= 1'b0;
            end else if (od_enter) begin
                od <= 1'b1;
            end
        end
    end

    assign pull_low  = (state == ST_PDRIVE) ||
                       (state == ST_SLOT && drv0 && cnt < tm.drv_us);
    assign overdrive = od;
endmodule

// File: rtl/sw_slave_phy.sv
module sw_slave_phy #(
    parameter int CLKS_PER_US    = 8,
    parameter int FALL_FILT_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_in,
    input  logic od_enter,
    input  logic tx_en,
    input  logic tx_bit,
    output logic rx_valid,
    output logic rx_bit,
    output logic reset_seen,
    output logic pull_low,
    output logic overdrive
);
    logic us_tick;
    logic tick_clr;
    logic low_qual;

    sw_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr),
        .tick (us_tick)
    );

    sw_fall_filter #(.FALL_FILT_CLKS(FALL_FILT_CLKS)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .bus_in    (bus_in),
        .overdrive (overdrive),
        .low_qual  (low_qual)
    );

    sw_slot_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_in     (bus_in),
        .low_qual   (low_qual),
        .us_tick    (us_tick),
        .tx_en      (tx_en),
        .tx_bit     (tx_bit),
        .od_enter   (od_enter),
        .tick_clr   (tick_clr),
        .pull_low   (pull_low),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit),
        .reset_seen (reset_seen),
        .overdrive  (overdrive)
    );
endmodule

// File: rtl/sw_slave_phy_chk.sv
module sw_slave_phy_chk (
    input logic clk,
    input logic rst,
    input logic bus_in,
    input logic od_enter,
    input logic rx_valid,
    input logic reset_seen,
    input logic pull_low,
    input logic overdrive
);
    // R1: reset indication is a single-cycle pulse
    assert_rst_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        reset_seen |=> !reset_seen);

    // R3: one strobe per decoded bit, never two in a row
    assert_rx_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4: a read-slot drive ends long before any reset threshold
    assert_no_drive_at_reset_R4: assert property (@(posedge clk) disable iff (rst)
        reset_seen |-> !pull_low);

    // R5: overdrive is only entered on request
    assert_od_enter_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(overdrive) |-> $past(od_enter));

    // R7: overdrive is only left while the wire is held low
    assert_od_exit_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(overdrive) |-> !bus_in);
endmodule

bind sw_slave_phy sw_slave_phy_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_in     (bus_in),
    .od_enter   (od_enter),
    .rx_valid   (rx_valid),
    .reset_seen (reset_seen),
    .pull_low   (pull_low),
    .overdrive  (overdrive)
);

// File: tb/tb_sw_slave_phy.sv
`timescale 1ns/1ps
module tb_sw_slave_phy;
    localparam int CLK_PERIOD = 10;
    localparam int NUS        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_low = 1'b0;
    logic od_enter = 1'b0;
    logic tx_en = 1'b0;
    logic tx_bit = 1'b1;
    logic bus_in;
    logic rx_valid, rx_bit, reset_seen, pull_low, overdrive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Monitor state
    int cyc = 0;
    int rx_cnt = 0;
    int rst_cnt = 0;
    int pull_cnt = 0;
    int pull_start = 0;
    int last_bit = 0;
    logic pull_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_in = !(master_low || pull_low);

    sw_slave_phy #(.CLKS_PER_US(NUS), .FALL_FILT_CLKS(3)) dut (
        .clk(clk), .rst(rst), .bus_in(bus_in), .od_enter(od_enter),
        .tx_en(tx_en), .tx_bit(tx_bit), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .reset_seen(reset_seen), .pull_low(pull_low), .overdrive(overdrive)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rx_valid) begin
            rx_cnt   <= rx_cnt + 1;
            last_bit <= int'(rx_bit);
        end
        if (reset_seen) rst_cnt <= rst_cnt + 1;
        if (pull_low) pull_cnt <= pull_cnt + 1;
        if (pull_low && !pull_prev) pull_start <= cyc;
        pull_prev <= pull_low;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * NUS) @(posedge clk);
    endtask

    task automatic low_us(input int n);
        @(posedge clk); #1 master_low = 1'b1;
        wait_us(n);
        #1 master_low = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(!pull_low && !rx_valid && !reset_seen && !overdrive, "R10 reset outputs",
              int'({pull_low, rx_valid, reset_seen, overdrive}), 0);
    endtask

    task automatic t_std_reset_presence();
        int r0, p0, rel;
        r0 = rst_cnt; p0 = pull_cnt;
        low_us(300);
        rel = cyc;
        wait_us(200);
        @(negedge clk);
        check(rst_cnt - r0 == 1, "R1 std reset pulses", rst_cnt - r0, 1);
        check(pull_cnt - p0 >= 120*NUS - 2 && pull_cnt - p0 <= 120*NUS + 2,
              "R2 std presence length", pull_cnt - p0, 120*NUS);
        check(pull_start - rel >= 29*NUS && pull_start - rel <= 31*NUS + 4,
              "R2 std presence delay", pull_start - rel, 30*NUS);
    endtask

    task automatic t_std_write();
        int x0, r0;
        x0 = rx_cnt; r0 = rst_cnt;
        low_us(5); wait_us(70);
        @(negedge clk);
        check(rx_cnt - x0 == 1, "R3 write-one strobes", rx_cnt - x0, 1);
        check(last_bit == 1, "R3 write-one value", last_bit, 1);
        x0 = rx_cnt;
        low_us(80); wait_us(20);
        @(negedge clk);
        check(rx_cnt - x0 == 1, "R3 write-zero strobes", rx_cnt - x0, 1);
        check(last_bit == 0, "R3 write-zero value", last_bit, 0);
        check(rst_cnt == r0, "R1 80us low is no reset", rst_cnt - r0, 0);
    endtask

    task automatic t_std_read();
        int x0, p0;
        x0 = rx_cnt; p0 = pull_cnt;
        tx_en = 1'b1; tx_bit = 1'b0;
        low_us(2); wait_us(70);
        @(negedge clk);
        check(pull_cnt - p0 >= 30*NUS - 2 && pull_cnt - p0 <= 30*NUS + 2,
              "R4 read-zero drive length", pull_cnt - p0, 30*NUS);
        p0 = pull_cnt;
        tx_bit = 1'b1;
        low_us(2); wait_us(70);
        @(negedge clk);
        check(pull_cnt == p0, "R4 read-one no drive", pull_cnt - p0, 0);
        check(rx_cnt == x0, "R4 no strobe in read slots", rx_cnt - x0, 0);
        tx_en = 1'b0;
    endtask

    task automatic t_filter();
        int x0, p0;
        x0 = rx_cnt; p0 = pull_cnt;
        @(posedge clk); #1 master_low = 1'b1;
        repeat (2) @(posedge clk);
        #1 master_low = 1'b0;
        wait_us(50);
        @(negedge clk);
        check(rx_cnt == x0, "R9 short low filtered", rx_cnt - x0, 0);
        check(pull_cnt == p0, "R9 short low no drive", pull_cnt - p0, 0);
    endtask

    task automatic t_holdoff();
        int x0;
        x0 = rx_cnt;
        low_us(5);
        repeat (2) @(posedge clk);
        #1 master_low = 1'b1;
        repeat (2*NUS) @(posedge clk);
        #1 master_low = 1'b0;
        wait_us(60);
        @(negedge clk);
        check(rx_cnt - x0 == 1, "R8 glitch in hold-off ignored", rx_cnt - x0, 1);
        x0 = rx_cnt;
        low_us(5);
        repeat (2) @(posedge clk);
        #1 master_low = 1'b1;
        wait_us(40);
        #1 master_low = 1'b0;
        wait_us(20);
        @(negedge clk);
        check(rx_cnt - x0 == 2, "R8 long low after hold-off opens slot", rx_cnt - x0, 2);
        check(last_bit == 0, "R8 new slot decodes 0", last_bit, 0);
    endtask

    task automatic t_od_write();
        int x0;
        @(posedge clk); #1 od_enter = 1'b1;
        @(posedge clk); #1 od_enter = 1'b0;
        @(negedge clk);
        check(overdrive == 1'b1, "R5 overdrive entered", int'(overdrive), 1);
        x0 = rx_cnt;
        low_us(1); wait_us(10);
        @(negedge clk);
        check(rx_cnt - x0 == 1 && last_bit == 1, "R5 od write-one", last_bit, 1);
        x0 = rx_cnt;
        low_us(8); wait_us(10);
        @(negedge clk);
        check(rx_cnt - x0 == 1 && last_bit == 0, "R5 od write-zero", last_bit, 0);
    endtask

    task automatic t_od_reset();
        int r0, p0;
        r0 = rst_cnt; p0 = pull_cnt;
        low_us(50); wait_us(40);
        @(negedge clk);
        check(rst_cnt - r0 == 1, "R6 od reset pulse", rst_cnt - r0, 1);
        check(pull_cnt - p0 >= 12*NUS - 2 && pull_cnt - p0 <= 12*NUS + 2,
              "R6 od presence length", pull_cnt - p0, 12*NUS);
        check(overdrive == 1'b1, "R6 stays overdrive", int'(overdrive), 1);
    endtask

    task automatic t_od_exit();
        int r0, p0;
        r0 = rst_cnt; p0 = pull_cnt;
        low_us(500);
        @(negedge clk);
        check(overdrive == 1'b0, "R7 long reset leaves overdrive", int'(overdrive), 0);
        wait_us(200);
        @(negedge clk);
        check(rst_cnt - r0 == 1, "R7 single reset pulse", rst_cnt - r0, 1);
        check(pull_cnt - p0 >= 120*NUS - 2 && pull_cnt - p0 <= 120*NUS + 2,
              "R7 standard presence after exit", pull_cnt - p0, 120*NUS);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        t_reset_state();
        #1 rst = 1'b0;
        wait_us(5);
        t_std_reset_presence();
        t_std_write();
        t_std_read();
        t_filter();
        t_holdoff();
        wait_us(10);
        t_od_write();
        t_od_reset();
        t_od_exit();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule